// File: doc/BRIEF.md
# Compact 8-bit Microcontroller Core

This block is a small accumulator-style processor that reads 16-bit instruction words from a program memory outside the block and runs them over eight 8-bit registers and a zero and a carry flag. Its ALU covers loads, logic, add and subtract (with and without carry), shifts and rotates. It also has a single-instruction bit reversal that a general-purpose core would need a dozen instructions to do. A 256-entry port space is reached through a port number, an output data bus, an input data bus and one-clock read and write strobes.

Every instruction takes exactly two clocks. In the first clock the program memory, which has one cycle of read latency, turns the address into an instruction word. At the end of the second clock that word is executed. Program flow covers conditional jumps, subroutine calls and returns through a small return stack, and one maskable interrupt. The interrupt sends the core to a fixed vector, saves the flags and restores them on return.

Top module: `mcu8_core`

## Requirements
- R1: A synchronous active-high reset sets the program address to 0x00, clears carry and zero, and disables the interrupt.
- R2: The address stays constant for two clocks, and a non-branching instruction advances it by exactly one per two clocks.
- R3: The opcode is bits [15:11], sX is bits [10:8], sY is bits [7:5] and the constant is bits [7:0]. LOAD (00000 constant, 00001 register) copies the operand into sX and leaves both flags unchanged.
- R4: AND/OR/XOR (opcodes 0001x/0010x/0011x, bit 11 = 1 picks sY) write sX, clear carry and set zero when the result is 0.
- R5: ADD 0100x, ADDCY 0101x, SUB 0110x and SUBCY 0111x write sX. Carry takes the carry-out or the borrow, the CY forms add or subtract the incoming carry, and zero reflects the result.
- R6: Opcode 10100 shifts sX. Bit 3 = 1 shifts right and bit 3 = 0 shifts left. Bits [2:0] choose what enters: 110 a zero, 111 a one, 010 the carry, 000 a copy of the edge bit, 100 the bit that leaves (rotate). Carry takes the bit shifted out.
- R7: Opcode 10101 reverses the bit order of sX and leaves both flags unchanged.
- R8: OUTPUT (10001 constant port, 11001 port from sY) drives the port number and sX on the output bus while the write strobe is high for exactly one clock.
- R9: INPUT (10000 constant port, 11000 port from sY) raises the read strobe for one clock with the port number valid and writes the input bus into sX.
- R10: JUMP 11010 and CALL 11011 go to bits [7:0]. RETURN 10010 goes to the address after the matching CALL. Bit 10 = 1 makes them conditional on bits [9:8]: 00 zero set, 01 zero clear, 10 carry set, 11 carry clear.
- R11: CALL pushes the address that follows it onto a return stack, and RETURN pops it, so a subroutine comes back to the caller.
- R12: Opcode 11110 sets the interrupt enable from bit 0. While enabled, a high interrupt input at the end of an instruction sends the core to address 0xFF, disables the interrupt and saves the flags. RETURNI 10110 restores the flags, returns, and sets the enable from bit 0. While disabled, the input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| address | output | 8 | Program memory address |
| instruction | input | 16 | Instruction word from program memory, one cycle after the address |
| port_id | output | 8 | Port number for INPUT/OUTPUT |
| out_port | output | 8 | Output data |
| write_strobe | output | 1 | One-clock pulse qualifying an output |
| in_port | input | 8 | Input data |
| read_strobe | output | 1 | One-clock pulse marking an input read |
| interrupt | input | 1 | Maskable interrupt request, level-sensitive |

## Verification
The assertions take for granted that the program memory returns its word exactly one clock after the address changes, so the instruction stays steady through the execute clock, and that the interrupt and input bus change only away from the active edge. The bench gives the memory a registered read, drives the interrupt and derives the input data from the port number at the falling edge. It raises the interrupt only at points set by output markers in the program, so every interrupt lands while the enable state is known.

// File: rtl/mcu8_pkg.sv
package mcu8_pkg;

  localparam int DW = 8;
  localparam int IW = 16;

  localparam logic [4:0] OP_SHIFT  = 5'b10100;
  localparam logic [4:0] OP_FLIP   = 5'b10101;
  localparam logic [4:0] OP_IN_K   = 5'b10000;
  localparam logic [4:0] OP_IN_R   = 5'b11000;
  localparam logic [4:0] OP_OUT_K  = 5'b10001;
  localparam logic [4:0] OP_OUT_R  = 5'b11001;
  localparam logic [4:0] OP_RET    = 5'b10010;
  localparam logic [4:0] OP_RETI   = 5'b10110;
  localparam logic [4:0] OP_JUMP   = 5'b11010;
  localparam logic [4:0] OP_CALL   = 5'b11011;
  localparam logic [4:0] OP_INTCTL = 5'b11110;

  // mirror image of a data byte
  function automatic logic [DW-1:0] bit_reverse(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
    return r;
  endfunction

  // returns {carry_out, result}
  function automatic logic [DW:0] shift_rot(input logic [DW-1:0] v,
                                            input logic cin,
                                            input logic [3:0] ctl);
    logic fill;
    logic right;
    right = ctl[3];
    case (ctl[2:0])
      3'b110:  fill = 1'b0;
      3'b111:  fill = 1'b1;
      3'b010:  fill = cin;
      3'b000:  fill = right ? v[DW-1] : v[0];
      default: fill = right ? v[0] : v[DW-1];
    endcase
    if (right) return {v[0], fill, v[DW-1:1]};
    else       return {v[DW-1], v[DW-2:0], fill};
  endfunction

  // returns {carry_or_borrow, result}
  function automatic logic [DW:0] add_sub(input logic [DW-1:0] a,
                                          input logic [DW-1:0] b,
                                          input logic cin,
                                          input logic sub,
                                          input logic use_c);
    logic [DW:0] ci;
    ci = {{DW{1'b0}}, use_c & cin};
    if (sub) return {1'b0, a} - {1'b0, b} - ci;
    else     return {1'b0, a} + {1'b0, b} + ci;
  endfunction

endpackage

// File: rtl/mcu8_regfile.sv
module mcu8_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DW       = 8
) (
  input  logic                        clk,
  input  logic                        we,
  input  logic [$clog2(NUM_REGS)-1:0] waddr,
  input  logic [DW-1:0]               wdata,
  input  logic [$clog2(NUM_REGS)-1:0] raddr_a,
  output logic [DW-1:0]               rdata_a,
  input  logic [$clog2(NUM_REGS)-1:0] raddr_b,
  output logic [DW-1:0]               rdata_b
);

  logic [DW-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/mcu8_alu.sv
module mcu8_alu
  import mcu8_pkg::*;
(
  input  logic [4:0]    op,
  input  logic [3:0]    ctl,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          zout,
  output logic          flag_we,
  output logic          reg_we
);

  logic [DW:0] sum_w;
  logic [DW:0] shf_w;

  assign sum_w = add_sub(a, b, cin, op[2], op[1]);
  assign shf_w = shift_rot(a, cin, ctl);

  always_comb begin
    res     = b;
    cout    = cin;
    flag_we = 1'b0;
    reg_we  = 1'b0;
    if (!op[4]) begin
      reg_we = 1'b1;
      case (op[3:1])
        3'd0: res = b;
        3'd1: begin res = a & b; cout = 1'b0; flag_we = 1'b1; end
        3'd2: begin res = a | b; cout = 1'b0; flag_we = 1'b1; end
        3'd3: begin res = a ^ b; cout = 1'b0; flag_we = 1'b1; end
        default: begin
          res     = sum_w[DW-1:0];
          cout    = sum_w[DW];
          flag_we = 1'b1;
        end
      endcase
    end else if (op == OP_SHIFT) begin
      res     = shf_w[DW-1:0];
      cout    = shf_w[DW];
      flag_we = 1'b1;
      reg_we  = 1'b1;
    end else if (op == OP_FLIP) begin
      res    = bit_reverse(a);
      reg_we = 1'b1;
    end
  end

  assign zout = (res == '0);

endmodule

// File: rtl/mcu8_stack.sv
module mcu8_stack #(
  parameter int DEPTH = 4,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] dout
);

  localparam int PW = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] top_w;

  assign top_w = ptr_q - 1'b1;
  assign dout  = mem[top_w];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      case ({push, pop})
        2'b10: begin mem[ptr_q] <= din; ptr_q <= ptr_q + 1'b1; end
        2'b01: ptr_q <= top_w;
        2'b11: mem[top_w] <= din;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mcu8_core.sv
module mcu8_core
  import mcu8_pkg::*;
#(
  parameter int             STACK_DEPTH = 4,
  parameter int             NUM_REGS    = 8,
  parameter logic [DW-1:0]  INT_VECTOR  = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  output logic [DW-1:0] address,
  input  logic [IW-1:0] instruction,
  output logic [DW-1:0] port_id,
  output logic [DW-1:0] out_port,
  output logic          write_strobe,
  input  logic [DW-1:0] in_port,
  output logic          read_strobe,
  input  logic          interrupt
);

  localparam int SW = $clog2(NUM_REGS);

  logic          phase_q;
  logic [DW-1:0] pc_q;
  logic          carry_q, zero_q, ie_q, sv_c_q, sv_z_q;

  logic [4:0]    op;
  logic [SW-1:0] sx, sy;
  logic [DW-1:0] kval;
  assign op   = instruction[15:11];
  assign sx   = instruction[8 +: SW];
  assign sy   = instruction[5 +: SW];
  assign kval = instruction[7:0];

  logic [DW-1:0] rx, ry, operand, alu_res, in_or_alu, stk_top;
  logic          alu_c, alu_z, alu_fwe, alu_rwe;

  // named events used by the assertions
  logic is_in, is_out, is_jump, is_call, is_ret, is_reti, is_intctl;
  logic cond_ok, branch_go, ret_go, take_irq, rf_we;
  logic push_w, pop_w;
  logic [DW-1:0] pc_seq, pc_after, push_data;
  logic c_nx, z_nx;

  assign is_in     = (op == OP_IN_K)  || (op == OP_IN_R);
  assign is_out    = (op == OP_OUT_K) || (op == OP_OUT_R);
  assign is_jump   = (op == OP_JUMP);
  assign is_call   = (op == OP_CALL);
  assign is_ret    = (op == OP_RET);
  assign is_reti   = (op == OP_RETI);
  assign is_intctl = (op == OP_INTCTL);

  assign operand = instruction[11] ? ry : kval;

  mcu8_regfile #(.NUM_REGS(NUM_REGS), .DW(DW)) u_rf (
    .clk    (clk),
    .we     (rf_we),
    .waddr  (sx),
    .wdata  (in_or_alu),
    .raddr_a(sx),
    .rdata_a(rx),
    .raddr_b(sy),
    .rdata_b(ry)
  );

  mcu8_alu u_alu (
    .op     (op),
    .ctl    (instruction[3:0]),
    .a      (rx),
    .b      (operand),
    .cin    (carry_q),
    .res    (alu_res),
    .cout   (alu_c),
    .zout   (alu_z),
    .flag_we(alu_fwe),
    .reg_we (alu_rwe)
  );

  mcu8_stack #(.DEPTH(STACK_DEPTH), .AW(DW)) u_stack (
    .clk (clk),
    .rst (rst),
    .push(push_w),
    .pop (pop_w),
    .din (push_data),
    .dout(stk_top)
  );

  always_comb begin
    if (!instruction[10]) cond_ok = 1'b1;
    else begin
      case (instruction[9:8])
        2'b00:   cond_ok = zero_q;
        2'b01:   cond_ok = !zero_q;
        2'b10:   cond_ok = carry_q;
        default: cond_ok = !carry_q;
      endcase
    end
  end

  assign branch_go = (is_jump || is_call) && cond_ok;
  assign ret_go    = (is_ret && cond_ok) || is_reti;
  assign pc_seq    = pc_q + 1'b1;
  assign pc_after  = branch_go ? kval : (ret_go ? stk_top : pc_seq);

  // an interrupt is not taken on a CALL, so at most one push per instruction
  assign take_irq  = phase_q && ie_q && interrupt && !is_call;
  assign push_w    = phase_q && ((is_call && cond_ok) || take_irq);
  assign pop_w     = phase_q && ret_go;
  assign push_data = take_irq ? pc_after : pc_seq;

  always_comb begin
    c_nx = carry_q;
    z_nx = zero_q;
    if (is_reti) begin
      c_nx = sv_c_q;
      z_nx = sv_z_q;
    end else if (alu_fwe) begin
      c_nx = alu_c;
      z_nx = alu_z;
    end
  end

  assign rf_we     = phase_q && (alu_rwe || is_in);
  assign in_or_alu = is_in ? in_port : alu_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      pc_q    <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
      ie_q    <= 1'b0;
      sv_c_q  <= 1'b0;
      sv_z_q  <= 1'b0;
    end else begin
      phase_q <= !phase_q;
      if (phase_q) begin
        pc_q    <= take_irq ? INT_VECTOR : pc_after;
        carry_q <= c_nx;
        zero_q  <= z_nx;
        if (take_irq) begin
          ie_q   <= 1'b0;
          sv_c_q <= c_nx;
          sv_z_q <= z_nx;
        end else if (is_intctl || is_reti) begin
          ie_q <= instruction[0];
        end
      end
    end
  end

  assign address      = pc_q;
  assign port_id      = instruction[14] ? ry : kval;
  assign out_port     = rx;
  assign write_strobe = phase_q && is_out;
  assign read_strobe  = phase_q && is_in;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    phase_q |-> $stable(address)); // R2

  AST_WSTROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    write_strobe |=> !write_strobe); // R8

  AST_RSTROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    read_strobe |=> !read_strobe); // R9

  AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (phase_q && op[4:1] == 4'b0000) |=> ($stable(carry_q) && $stable(zero_q))); // R3

  AST_FLIP_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (phase_q && op == OP_FLIP) |=> ($stable(carry_q) && $stable(zero_q))); // R7

  AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (phase_q && op[4:3] == 2'b00 && op[2:1] != 2'b00) |=> !carry_q); // R4

  AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> (address == INT_VECTOR && !ie_q)); // R12

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (phase_q && !ie_q && !is_intctl && !is_reti) |=> !ie_q); // R12

endmodule

// File: tb/tb_mcu8_core.sv
`timescale 1ns/1ps
module tb_mcu8_core;
  import mcu8_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        interrupt = 1'b0;
  logic [7:0]  address, port_id, out_port, in_port;
  logic [15:0] rom_q;
  logic        write_strobe, read_strobe;
  logic [15:0] rom [256];

  always #10 clk = ~clk;

  always_ff @(posedge clk) rom_q <= rom[address];
  assign in_port = port_id ^ 8'hA5;

  mcu8_core dut (
    .clk(clk), .rst(rst), .address(address), .instruction(rom_q),
    .port_id(port_id), .out_port(out_port), .write_strobe(write_strobe),
    .in_port(in_port), .read_strobe(read_strobe), .interrupt(interrupt)
  );

  int checks = 0;
  int fails  = 0;
  int a      = 0;
  int reads  = 0;
  logic [7:0] qp[$];
  logic [7:0] qd[$];
  string      qr[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ek(input logic [4:0] op, input int x, input int k);
    return {op, 3'(x), 8'(k)};
  endfunction
  function automatic logic [15:0] er(input logic [4:0] op, input int x, input int y);
    return {op, 3'(x), 3'(y), 5'b0};
  endfunction

  task automatic emit(input logic [15:0] w);
    rom[a] = w;
    a++;
  endtask

  // driver side of the scoreboard
  task automatic expect_out(input int p, input int d, input string req);
    qp.push_back(8'(p));
    qd.push_back(8'(d));
    qr.push_back(req);
  endtask

  task automatic out_k(input int x, input int p, input int d, input string req);
    emit(ek(OP_OUT_K, x, p));
    expect_out(p, d, req);
  endtask

  // monitor side: pop and compare on each write strobe
  always @(negedge clk) begin
    if (!rst && write_strobe) begin
      if (qp.size() == 0) begin
        check(1'b0, "R8", "unexpected write to port", port_id, 0);
      end else begin
        logic [7:0] ep, ed;
        string rq;
        ep = qp.pop_front();
        ed = qd.pop_front();
        rq = qr.pop_front();
        check(port_id == ep, rq, "port number", port_id, ep);
        check(out_port == ed, rq, "output data", out_port, ed);
      end
      case (port_id)
        8'hE1, 8'hE2, 8'hE5: interrupt = 1'b1;
        8'hE3, 8'hE6, 8'hEE: interrupt = 1'b0;
        default: ;
      endcase
    end
    if (!rst && read_strobe) reads++;
  end

  task automatic build_program();
    for (int i = 0; i < 256; i++) rom[i] = 16'h0000;
    // R1: carry clear after reset, seen through ADDCY
    emit(ek(5'b00000, 0, 8'h00));
    emit(ek(5'b01010, 0, 8'h00));
    out_k(0, 8'h0F, 8'h00, "R1");
    // R4 AND register form
    emit(ek(5'b00000, 0, 8'h3C));
    emit(ek(5'b00000, 1, 8'h0F));
    emit(er(5'b00011, 0, 1));
    out_k(0, 8'h10, 8'h0C, "R4");
    // R4 XOR to zero, R10 JUMP Z taken
    emit(ek(5'b00110, 1, 8'h0F));
    emit(ek(OP_JUMP, 3'b100, a + 2));
    emit(ek(OP_OUT_K, 1, 8'hBD));
    // R5 ADD with carry out
    emit(ek(5'b00000, 2, 8'hF0));
    emit(ek(5'b01000, 2, 8'h20));
    out_k(2, 8'h11, 8'h10, "R5");
    // R3 LOAD keeps carry, ADDCY adds it
    emit(ek(5'b00000, 3, 8'h00));
    emit(ek(5'b01010, 3, 8'h00));
    out_k(3, 8'h12, 8'h01, "R3");
    // R5 SUB borrow, SUBCY consumes it
    emit(ek(5'b01100, 3, 8'h02));
    emit(ek(5'b01110, 3, 8'h00));
    out_k(3, 8'h13, 8'hFE, "R5");
    // R10 JUMP C not taken
    emit(ek(OP_JUMP, 3'b110, a + 2));
    out_k(3, 8'h14, 8'hFE, "R10");
    // R7 FLIP
    emit(ek(5'b00000, 4, 8'hB1));
    emit(ek(OP_FLIP, 4, 0));
    out_k(4, 8'h15, 8'h8D, "R7");
    // R6 shift and rotate variants
    emit(ek(OP_SHIFT, 4, 4'b0110));
    out_k(4, 8'h16, 8'h1A, "R6");
    emit(ek(OP_SHIFT, 4, 4'b1100));
    out_k(4, 8'h17, 8'h0D, "R6");
    emit(ek(OP_SHIFT, 4, 4'b1111));
    out_k(4, 8'h18, 8'h86, "R6");
    emit(ek(OP_SHIFT, 4, 4'b0010));
    out_k(4, 8'h19, 8'h0D, "R6");
    emit(ek(5'b00000, 5, 8'h90));
    emit(ek(OP_SHIFT, 5, 4'b1000));
    out_k(5, 8'h1A, 8'hC8, "R6");
    // R8 port taken from sY
    emit(ek(5'b00000, 6, 8'h1B));
    emit(er(OP_OUT_R, 5, 6));
    expect_out(8'h1B, 8'hC8, "R8");
    // R9 input, constant and register port
    emit(ek(OP_IN_K, 7, 8'h42));
    out_k(7, 8'h1C, 8'h42 ^ 8'hA5, "R9");
    emit(er(OP_IN_R, 0, 6));
    out_k(0, 8'h1D, 8'h1B ^ 8'hA5, "R9");
    // R11 CALL / RETURN
    emit(ek(OP_CALL, 0, 8'h60));
    expect_out(8'h1E, 8'h77, "R11");
    out_k(1, 8'h1F, 8'h77, "R11");
    // R12 interrupt masked while disabled
    emit(ek(5'b00000, 1, 8'h00));
    emit(ek(5'b01100, 1, 8'h01));
    out_k(1, 8'hE2, 8'hFF, "R12");
    emit(er(5'b00001, 0, 0));
    emit(er(5'b00001, 0, 0));
    out_k(1, 8'hE3, 8'hFF, "R12");
    // R12 enabled: vector, ISR, flags restored
    emit(ek(OP_INTCTL, 0, 8'h01));
    out_k(1, 8'hE1, 8'hFF, "R12");
    expect_out(8'hEE, 8'h00, "R12");
    for (int i = 0; i < 4; i++) emit(er(5'b00001, 0, 0));
    emit(ek(5'b00000, 2, 8'h00));
    emit(ek(5'b01010, 2, 8'h00));
    out_k(2, 8'hE4, 8'h01, "R12");
    // R12 RETURNI DISABLE leaves interrupt masked
    out_k(1, 8'hE5, 8'hFF, "R12");
    emit(er(5'b00001, 0, 0));
    emit(er(5'b00001, 0, 0));
    out_k(1, 8'hE6, 8'hFF, "R12");
    emit(ek(OP_JUMP, 0, a));
    // subroutine
    rom[8'h60] = ek(5'b00000, 1, 8'h77);
    rom[8'h61] = ek(OP_OUT_K, 1, 8'h1E);
    rom[8'h62] = ek(OP_RET, 0, 0);
    // vector and handler
    rom[8'hFF] = ek(OP_JUMP, 0, 8'hC0);
    rom[8'hC0] = ek(5'b00010, 3, 8'h00);
    rom[8'hC1] = ek(OP_OUT_K, 3, 8'hEE);
    rom[8'hC2] = ek(OP_RETI, 0, 8'h00);
  endtask

  initial begin
    int done_addr;
    int wd;
    build_program();
    done_addr = a - 1;
    repeat (4) begin
      @(negedge clk);
      check(address == 8'h00, "R1", "address in reset", address, 0);
    end
    rst = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(address == 8'(k / 2), "R2", "address cadence", address, k / 2);
    end
    wd = 0;
    while (qp.size() != 0 && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 20000) check(1'b0, "R2", "watchdog expired, pending outputs", qp.size(), 0);
    repeat (40) @(negedge clk);
    check(address == 8'(done_addr), "R10", "final self-jump address", address, done_addr);
    check(reads == 2, "R9", "read strobe count", reads, 2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule